// File: doc/BRIEF.md
# Reed-Solomon inner frame decoder

This block is the first stage of a two-level Reed-Solomon decoding chain. It receives 32-symbol codewords of bytes and checks each one against its four check symbols. A codeword that is clean or carries one bad symbol is passed on as 28 correct data bytes. A codeword that is damaged more heavily is passed on exactly as received, and every byte of it is marked unreliable so that a later stage can treat those bytes as erasures. The four check bytes are never forwarded.

The input is a byte stream qualified by a valid strobe, with a start marker on the first byte of each codeword. The output is a byte stream with a valid strobe, a per-byte reliability flag that is constant across a frame, and a last marker on the 28th byte. A frame is held in one of two internal banks until its verdict is known. The next frame fills the other bank while the held frame is sent out, so back-to-back input at one byte per clock is sustained.

Top module: `rs_inner_decoder`

## Requirements
- R1: A byte taken with `in_valid` and `in_sof` high opens a frame at position 0. Each later valid byte takes the next position, and position 31 closes the frame. Positions 0..27 are data and 28..31 are check bytes, which never appear at the output. Each complete frame yields exactly 28 output beats, and `out_last` is high on the 28th beat and on no other beat.
- R2: Arithmetic is in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1 and generator alpha = 0x02. The received byte at position p has exponent index i = 31-p. Syndrome S_j is the sum of r_i·alpha^(i·j) for j = 0..3. When all four syndromes are zero, the 28 data bytes leave unchanged and `out_flag` is 0.
- R3: A frame with exactly one wrong byte at any data position 0..27 leaves with that byte restored and `out_flag` 0.
- R4: A frame with exactly one wrong byte at a check position 28..31 leaves its 28 data bytes unchanged and `out_flag` 0.
- R5: A frame whose syndromes do not match one single error leaves its 28 data bytes exactly as received, with `out_flag` 1 on all of them. A single error is matched when S0, S1 and S2 are nonzero, S1² = S0·S2, S2² = S1·S3, and S1 = S0·alpha^k for some k in 0..31.
- R6: The 28 beats of a frame are output on consecutive cycles, and `out_flag` does not change within a frame.
- R7: A start marker inside an open frame drops the partial frame and opens a new one. Valid bytes that arrive while no frame is open are ignored and produce no output.
- R8: Frames may arrive back to back with no idle cycle between them, or with idle cycles inside a frame. Output frames leave in arrival order, and no output is produced before a frame has been completely received.
- R9: Synchronous active-high `rst` clears all state: no output beat appears in the cycle after reset, and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | First byte of a codeword |
| in_sym | input | 8 | Received code byte |
| out_valid | output | 1 | Output byte qualifier |
| out_sym | output | 8 | Data byte, corrected where possible |
| out_flag | output | 1 | 1 when the frame could not be trusted |
| out_last | output | 1 | Marks the 28th data byte of a frame |

## Verification
The bench builds genuine codewords with its own systematic encoder and then adds zero, one or two byte errors. The single-error cases hit the first and last data positions, a middle data position, and the first and last check positions. These separate correction of data from the harmless check-byte case and exercise the edges of the location search. The two-error cases place both errors in data, both in check bytes, one in each, and both at the outer data positions; these must all be flagged and passed through untouched, never miscorrected. Directed runs add idle cycles inside a frame, a frame abandoned by a new start marker, and stray bytes with no open frame.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int SYM_W  = 8;
    localparam int N_SYM  = 32;
    localparam int N_PAR  = 4;
    localparam int N_DATA = N_SYM - N_PAR;
    localparam int POS_W  = $clog2(N_SYM);
    localparam int CNT_W  = POS_W + 1;
    localparam int N_BANK = 2;

    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;

    // Outcome of one frame's syndrome analysis
    typedef struct packed {
        logic             flag;  // frame untrusted
        logic             fix;   // a data byte needs patching
        logic [POS_W-1:0] pos;   // arrival position of that byte
        sym_t             val;   // value to add back
    } verdict_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int n = 0; n < SYM_W; n++) begin
            if (b[n]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int e);
        sym_t p;
        p = sym_t'(1);
        for (int n = 0; n < e; n++) p = gf_mul(p, sym_t'(2));
        return p;
    endfunction

endpackage

// File: rtl/rs_syndrome_acc.sv
module rs_syndrome_acc
    import rs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  sym_t                  in_sym,
    output logic                  wr_en,
    output logic [POS_W-1:0]      wr_pos,
    output sym_t                  wr_sym,
    output logic                  last_take,
    output logic                  done,
    output sym_t [N_PAR-1:0]      synd_o
);

    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(N_SYM - 1);
    localparam logic [CNT_W-1:0] DATA_ENDS = CNT_W'(N_DATA);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos_now;
    logic             accept;
    sym_t             synd_q [N_PAR];

    assign accept    = in_valid && (in_sof || open_q);
    assign pos_now   = in_sof ? '0 : cnt_q;
    assign last_take = accept && (pos_now == LAST_POS);
    assign wr_en     = accept && (pos_now < DATA_ENDS);
    assign wr_pos    = pos_now[POS_W-1:0];
    assign wr_sym    = in_sym;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= last_take;
            if (accept) begin
                cnt_q  <= pos_now + CNT_W'(1);
                open_q <= !last_take;
            end
        end
    end

    // Horner accumulation: each syndrome is scaled by its own alpha power per byte
    for (genvar j = 0; j < N_PAR; j++) begin : g_syn
        localparam sym_t STEP = gf_alpha_pow(j);
        always_ff @(posedge clk) begin
            if (rst)         synd_q[j] <= '0;
            else if (accept) synd_q[j] <= gf_mul(in_sof ? sym_t'(0) : synd_q[j], STEP) ^ in_sym;
        end
        assign synd_o[j] = synd_q[j];
    end

endmodule

// File: rtl/rs_error_locate.sv
module rs_error_locate
    import rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  sym_t [N_PAR-1:0] synd_i,
    output logic             vld_o,
    output verdict_t         verdict_o
);

    logic [N_SYM-1:0] match;
    logic [POS_W-1:0] loc;
    logic             all_zero;
    logic             consistent;
    logic             single;
    verdict_t         v;

    // Compare S1 against S0 scaled by every candidate location at once
    for (genvar k = 0; k < N_SYM; k++) begin : g_loc
        localparam sym_t AK = gf_alpha_pow(k);
        assign match[k] = (gf_mul(synd_i[0], AK) == synd_i[1]);
    end

    always_comb begin
        loc = '0;
        for (int k = 0; k < N_SYM; k++) begin
            if (match[k]) loc = POS_W'(k);
        end
    end

    assign all_zero   = (synd_i == '0);
    assign consistent = (synd_i[0] != '0) && (synd_i[1] != '0) && (synd_i[2] != '0)
                     && (gf_mul(synd_i[1], synd_i[1]) == gf_mul(synd_i[0], synd_i[2]))
                     && (gf_mul(synd_i[2], synd_i[2]) == gf_mul(synd_i[1], synd_i[3]));
    assign single     = consistent && (|match);

    always_comb begin
        v.flag = !all_zero && !single;
        v.fix  = single && (loc >= POS_W'(N_PAR));
        v.pos  = POS_W'(N_SYM - 1) - loc;
        v.val  = synd_i[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o     <= 1'b0;
            verdict_o <= '0;
        end else begin
            vld_o <= go;
            if (go) verdict_o <= v;
        end
    end

endmodule

// File: rtl/rs_frame_store.sv
module rs_frame_store
    import rs_pkg::*;
(
    input  logic                        clk,
    input  logic                        we,
    input  logic [$clog2(N_BANK)-1:0]   wbank,
    input  logic [POS_W-1:0]            wpos,
    input  sym_t                        wdata,
    input  logic [$clog2(N_BANK)-1:0]   rbank,
    input  logic [POS_W-1:0]            rpos,
    output sym_t                        rdata
);

    sym_t mem [N_BANK][N_DATA];

    always_ff @(posedge clk) begin
        if (we) mem[wbank][wpos] <= wdata;
    end

    assign rdata = mem[rbank][rpos];

endmodule

// File: rtl/rs_inner_decoder.sv
module rs_inner_decoder
    import rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_sym,
    output logic       out_valid,
    output logic [7:0] out_sym,
    output logic       out_flag,
    output logic       out_last
);

    localparam int                BANK_W   = $clog2(N_BANK);
    localparam logic [POS_W-1:0]  LAST_OUT = POS_W'(N_DATA - 1);

    logic             wr_en;
    logic [POS_W-1:0] wr_pos;
    sym_t             wr_sym;
    logic             last_take;
    logic             syn_done;
    sym_t [N_PAR-1:0] synd;
    logic             loc_vld;
    verdict_t         verdict;

    logic [BANK_W-1:0] wr_bank;
    logic [BANK_W-1:0] fin_bank;
    logic [BANK_W-1:0] rd_bank;
    logic [N_BANK-1:0] full;
    verdict_t          bank_v [N_BANK];
    logic              busy;
    logic [POS_W-1:0]  idx;
    sym_t              rd_sym;
    verdict_t          cur;

    rs_syndrome_acc u_syn (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sym    (in_sym),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos),
        .wr_sym    (wr_sym),
        .last_take (last_take),
        .done      (syn_done),
        .synd_o    (synd)
    );

    rs_error_locate u_loc (
        .clk       (clk),
        .rst       (rst),
        .go        (syn_done),
        .synd_i    (synd),
        .vld_o     (loc_vld),
        .verdict_o (verdict)
    );

    rs_frame_store u_mem (
        .clk   (clk),
        .we    (wr_en),
        .wbank (wr_bank),
        .wpos  (wr_pos),
        .wdata (wr_sym),
        .rbank (rd_bank),
        .rpos  (idx),
        .rdata (rd_sym)
    );

    // Fill side: swap banks the moment a frame's final byte is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank  <= '0;
            fin_bank <= '0;
        end else if (last_take) begin
            wr_bank  <= wr_bank + BANK_W'(1);
            fin_bank <= wr_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (loc_vld) bank_v[fin_bank] <= verdict;
    end

    assign cur = bank_v[rd_bank];

    // Drain side: emit 28 beats from the oldest complete bank
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            idx       <= '0;
            rd_bank   <= '0;
            full      <= '0;
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_flag  <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (busy) begin
                out_valid <= 1'b1;
                out_sym   <= rd_sym ^ ((cur.fix && cur.pos == idx) ? cur.val : sym_t'(0));
                out_flag  <= cur.flag;
                out_last  <= (idx == LAST_OUT);
                if (idx == LAST_OUT) begin
                    busy          <= 1'b0;
                    full[rd_bank] <= 1'b0;
                    rd_bank       <= rd_bank + BANK_W'(1);
                end else begin
                    idx <= idx + POS_W'(1);
                end
            end else if (full[rd_bank]) begin
                busy <= 1'b1;
                idx  <= '0;
            end
            if (loc_vld) full[fin_bank] <= 1'b1;
        end
    end

endmodule

// File: rtl/rs_inner_decoder_chk.sv
module rs_inner_decoder_chk
    import rs_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic out_valid,
    input logic out_flag,
    input logic out_last,
    input logic frame_done
);

    logic [POS_W-1:0] beat;
    logic [2:0]       pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat    <= '0;
            pending <= '0;
        end else begin
            if (out_valid) beat <= out_last ? '0 : beat + POS_W'(1);
            pending <= pending + (frame_done ? 3'd1 : 3'd0) - ((out_valid && out_last) ? 3'd1 : 3'd0);
        end
    end

    assert_last_on_final_beat_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (beat == POS_W'(N_DATA - 1))));

    assert_last_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_flag_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_valid && $stable(out_flag)));

    assert_no_early_output_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pending != 3'd0));

    assert_bank_limit_R8: assert property (@(posedge clk) disable iff (rst)
        pending <= 3'd2);

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

bind rs_inner_decoder rs_inner_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_flag   (out_flag),
    .out_last   (out_last),
    .frame_done (syn_done)
);

// File: tb/sim_rs_inner_decoder.sv
`timescale 1ns/1ps
module sim_rs_inner_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_sym = 8'h00;
    logic       out_valid;
    logic [7:0] out_sym;
    logic       out_flag;
    logic       out_last;

    always #2.5 clk = ~clk;

    rs_inner_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sym(in_sym),
        .out_valid(out_valid), .out_sym(out_sym), .out_flag(out_flag), .out_last(out_last)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // seed, error1 position, error1 value, error2 position, error2 value (FF = none)
    localparam logic [39:0] VEC [12] = '{
        40'h11_FF_00_FF_00,
        40'h5A_00_3C_FF_00,
        40'h77_1B_81_FF_00,
        40'hC3_0D_FF_FF_00,
        40'h21_1C_55_FF_00,
        40'h9E_1F_01_FF_00,
        40'h40_03_10_19_20,
        40'h08_1E_7F_1F_02,
        40'hE7_00_01_1B_01,
        40'h00_FF_00_FF_00,
        40'h6B_10_FF_1D_FF,
        40'h33_0A_80_FF_00
    };

    logic [7:0] gen [5];
    logic [7:0] cw [32];
    logic [7:0] rx [32];

    logic [7:0] exp_sym  [2048];
    logic       exp_flag [2048];
    string      exp_req  [2048];
    int         exp_n = 0;
    logic [7:0] got_sym  [2048];
    logic       got_flag [2048];
    logic       got_last [2048];
    int         got_n = 0;

    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc = 8'h00;
        for (int n = 7; n >= 0; n--) begin
            acc = acc[7] ? ((acc << 1) ^ 8'h1D) : (acc << 1);
            if (b[n]) acc = acc ^ a;
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && got_n < 2048) begin
            got_sym[got_n]  = out_sym;
            got_flag[got_n] = out_flag;
            got_last[got_n] = out_last;
            got_n++;
        end
    end

    task automatic build(input logic [7:0] seed, input int e1p, input logic [7:0] e1v,
                         input int e2p, input logic [7:0] e2v);
        logic [7:0] r [4];
        logic [7:0] fb;
        for (int k = 0; k < 4; k++) r[k] = 8'h00;
        for (int p = 0; p < 28; p++) begin
            cw[p] = seed + 8'(p * 29);
            fb    = cw[p] ^ r[3];
            r[3]  = r[2] ^ bmul(fb, gen[3]);
            r[2]  = r[1] ^ bmul(fb, gen[2]);
            r[1]  = r[0] ^ bmul(fb, gen[1]);
            r[0]  = bmul(fb, gen[0]);
        end
        cw[28] = r[3]; cw[29] = r[2]; cw[30] = r[1]; cw[31] = r[0];
        for (int p = 0; p < 32; p++) rx[p] = cw[p];
        if (e1p < 32) rx[e1p] = rx[e1p] ^ e1v;
        if (e2p < 32) rx[e2p] = rx[e2p] ^ e2v;
    endtask

    task automatic send_frame(input logic [7:0] seed, input int e1p, input logic [7:0] e1v,
                              input int e2p, input logic [7:0] e2v, input int gap_at);
        logic  fl;
        string req;
        build(seed, e1p, e1v, e2p, e2v);
        fl = (e1p < 32) && (e2p < 32);
        if (fl)            req = "R5";
        else if (e1p < 28) req = "R3";
        else if (e1p < 32) req = "R4";
        else               req = "R2";
        for (int p = 0; p < 28; p++) begin
            exp_sym[exp_n]  = fl ? rx[p] : cw[p];
            exp_flag[exp_n] = fl;
            exp_req[exp_n]  = req;
            exp_n++;
        end
        for (int p = 0; p < 32; p++) begin
            if (p == gap_at) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_sof = 1'b0;
                @(posedge clk); #1;
                in_valid = 1'b0;
            end else begin
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_sof   = (p == 0);
            in_sym   = rx[p];
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0] nxt [5];
        logic [7:0] root;
        gen[0] = 8'h01;
        for (int k = 1; k < 5; k++) gen[k] = 8'h00;
        root = 8'h01;
        for (int r = 0; r < 4; r++) begin
            nxt[0] = bmul(gen[0], root);
            for (int k = 1; k < 5; k++) nxt[k] = gen[k-1] ^ bmul(gen[k], root);
            for (int k = 0; k < 5; k++) gen[k] = nxt[k];
            root = bmul(root, 8'h02);
        end

        // R9: no output during or right after reset
        repeat (4) @(posedge clk);
        @(negedge clk); check("R9 during reset", {31'd0, out_valid}, 32'd0);
        @(posedge clk); #1; rst = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); check("R9 after reset", {31'd0, out_valid}, 32'd0);
        end

        // Table of frames, back to back (R8)
        for (int v = 0; v < 12; v++) begin
            send_frame(VEC[v][39:32],
                       (VEC[v][31:24] == 8'hFF) ? 99 : int'(VEC[v][31:24]), VEC[v][23:16],
                       (VEC[v][15:8]  == 8'hFF) ? 99 : int'(VEC[v][15:8]),  VEC[v][7:0], -1);
        end
        idle(80);

        // R8: idle cycles inside a frame, single error corrected
        send_frame(8'hA5, 5, 8'h44, 99, 8'h00, 17);
        idle(80);

        // R7: partial frame abandoned by a new start marker
        build(8'h3E, 99, 8'h00, 99, 8'h00);
        for (int p = 0; p < 10; p++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sof = (p == 0); in_sym = rx[p] ^ 8'h5C;
        end
        send_frame(8'h3E, 20, 8'h0F, 99, 8'h00, -1);
        // R7: stray bytes with no open frame
        for (int p = 0; p < 6; p++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sof = 1'b0; in_sym = 8'(p * 7 + 1);
        end
        idle(100);

        check("R7 R1 beat count", got_n, exp_n);
        for (int q = 0; q < exp_n && q < got_n; q++) begin
            check(exp_req[q], {24'd0, got_sym[q]}, {24'd0, exp_sym[q]});
            check((exp_flag[q] ? "R5 flag" : "R6 flag"), {31'd0, got_flag[q]}, {31'd0, exp_flag[q]});
            check("R1 last", {31'd0, got_last[q]}, {31'd0, (q % 28) == 27});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule